// File: doc/BRIEF.md
# ECC Error Response Controller

This block sits between a host bus port and the data path of an SDRAM word that is protected by a single-error-correct, double-error-detect code. Each access is presented for one cycle with its kind: a read (one beat or one beat of a burst), a partial write that is carried out as read-modify-write, a full write, or a background scrub. The word fetched from memory arrives with it. The block decodes that word and picks the response. It can correct and forward the data, merge host bytes into the corrected word, write the word back, or hold the write off.

Every response is registered and appears one clock after the access. The same block encodes each word that goes back to memory. The first detected error is captured in a status register together with its class, access kind and address. An interrupt level and a machine-check level, each gated by its own enable, are raised and stay high until software clears the status.

Top module: `ecc_resp_ctrl`

## Requirements
- R1: A full write (kind 2) drives `mem_we` with `mem_wdata` equal to `acc_wdata` one cycle later. The 8-bit check word is laid out as follows. Data bit j takes the j-th Hamming position that is not a power of two, counting upward from 3. Check bit i (i = 0..6) is the even parity of the data bits whose position has bit i set. Check bit 7 is the even parity of all 64 data bits and check bits 0..6.
- R2: A read (kind 0) or a partial write (kind 1) raises `host_ack` for exactly one cycle, one cycle after the access. The host cycle ends normally for every error class.
- R3: A read returns the stored data on `host_rdata` when the word has no error. When exactly one bit of the 72 stored bits is flipped, it returns the corrected data. Outside a read response, `host_rdata` is zero.
- R4: A read with an uncorrectable error returns the raw memory data. The error class is recorded as 2 (single-bit errors are recorded as 1).
- R5: A partial write with no error or with a correctable error writes back the corrected memory word. In that word, each byte lane whose `acc_be` bit is set is replaced by the matching byte of `acc_wdata`.
- R6: A partial write with an uncorrectable error performs no memory write.
- R7: A scrub (kind 3) never raises `host_ack`. It writes the corrected word back only for a correctable error while `scrub_wb_en` is high. It never writes on a clean or an uncorrectable word, and it never raises `mchk`.
- R8: The first detected error latches `stat_valid`, `stat_class`, `stat_kind` and `stat_addr` on the cycle after the access. Later errors leave the latched fields unchanged while `stat_valid` is high.
- R9: `stat_clr` drops the status, `err_irq` and `mchk` on the next cycle. When an error arrives in the same cycle as the clear, that error is latched instead.
- R10: Any detected error with `irq_en` high sets `err_irq`. An uncorrectable error on a read or a partial write with `mchk_en` high sets `mchk`. Both are levels that hold until cleared.
- R11: A full write ignores the memory word. A corrupted `mem_rdata` on a full write causes no status, no interrupt and no machine check.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 read, 1 partial write, 2 full write, 3 scrub |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 64 | Host write data |
| acc_be | input | 8 | Host byte enables for partial writes |
| mem_rdata | input | 64 | Data word read from memory |
| mem_rcheck | input | 8 | Check word read from memory |
| irq_en | input | 1 | Interrupt enable |
| mchk_en | input | 1 | Machine-check enable |
| scrub_wb_en | input | 1 | Scrub write-back enable |
| stat_clr | input | 1 | Clear status and flags |
| host_ack | output | 1 | Host cycle completes normally |
| host_rdata | output | 64 | Data returned to the host |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 64 | Data word to write |
| mem_wcheck | output | 8 | Check word to write |
| err_irq | output | 1 | Error interrupt level |
| mchk | output | 1 | Machine-check level |
| stat_valid | output | 1 | Status holds an error |
| stat_class | output | 2 | Latched class: 1 single, 2 uncorrectable |
| stat_kind | output | 2 | Latched access kind |
| stat_addr | output | 32 | Latched address |

## Verification
The bench builds the block at its defaults: a 64-bit word with a 32-bit address. At that size the 72-bit stored word has seven Hamming bits and an overall parity bit, and the bench can flip any single bit or pair of bits in data or check positions, including the parity bit alone. The eight byte lanes let the merge be tried with sparse, full and empty enable patterns. The same width also exposes every class outcome on every access kind, together with the clear-versus-new-error collision in the status register.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    typedef enum logic [1:0] {
        ACC_READ   = 2'd0,
        ACC_PWRITE = 2'd1,
        ACC_FWRITE = 2'd2,
        ACC_SCRUB  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_DOUBLE = 2'd2
    } err_class_e;

    // Number of Hamming bits needed to cover dw data bits.
    function automatic int hbits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // Hamming position of data bit j: the j-th non-power-of-two from 3 up.
    function automatic int data_pos(input int j);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 3; p < j + 40; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == j) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
    import ecc_pkg::*;
#(
    parameter int DW = 64,
    localparam int HB = hbits(DW)
) (
    input  logic [DW-1:0] data_i,
    output logic [HB:0]   check_o
);

    function automatic logic [DW-1:0] cover_mask(input int i);
        logic [DW-1:0] m;
        m = '0;
        for (int j = 0; j < DW; j++) begin
            if (((data_pos(j) >> i) & 1) == 1) m[j] = 1'b1;
        end
        return m;
    endfunction

    logic [HB-1:0] ham;

    for (genvar i = 0; i < HB; i++) begin : g_ham
        localparam logic [DW-1:0] MASK = cover_mask(i);
        assign ham[i] = ^(data_i & MASK);
    end

    assign check_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
    import ecc_pkg::*;
#(
    parameter int DW = 64,
    localparam int HB = hbits(DW)
) (
    input  logic [DW-1:0] data_i,
    input  logic [HB:0]   check_i,
    output err_class_e    class_o,
    output logic [DW-1:0] data_o
);

    logic [HB:0]   recomputed;
    logic [HB-1:0] syn;
    logic          odd;
    logic          fixable;

    ecc_encode #(.DW(DW)) u_reenc (
        .data_i  (data_i),
        .check_o (recomputed)
    );

    assign syn     = recomputed[HB-1:0] ^ check_i[HB-1:0];
    // parity over all stored bits, rebuilt from the recomputed overall bit
    assign odd     = recomputed[HB] ^ check_i[HB] ^ (^syn);
    assign fixable = odd && (int'(syn) <= DW + HB);

    always_comb begin
        if (syn == '0 && !odd) class_o = ERR_NONE;
        else if (fixable)      class_o = ERR_SINGLE;
        else                   class_o = ERR_DOUBLE;
    end

    for (genvar j = 0; j < DW; j++) begin : g_fix
        localparam int POS = data_pos(j);
        assign data_o[j] = data_i[j] ^ (fixable && (int'(syn) == POS));
    end

endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
    import ecc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_i,
    input  err_class_e    cls_i,
    input  acc_kind_e     kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic          mchk_cause_i,
    input  logic          irq_en_i,
    input  logic          mchk_en_i,
    input  logic          clr_i,
    output logic          valid_o,
    output err_class_e    cls_o,
    output acc_kind_e     kind_o,
    output logic [AW-1:0] addr_o,
    output logic          irq_o,
    output logic          mchk_o
);

    typedef struct packed {
        logic          valid;
        err_class_e    cls;
        acc_kind_e     kind;
        logic [AW-1:0] addr;
        logic          irq;
        logic          mchk;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.valid = 1'b0;
            st_d.cls   = ERR_NONE;
            st_d.kind  = ACC_READ;
            st_d.addr  = '0;
            st_d.irq   = 1'b0;
            st_d.mchk  = 1'b0;
        end
        if (ev_i && (!st_q.valid || clr_i)) begin
            st_d.valid = 1'b1;
            st_d.cls   = cls_i;
            st_d.kind  = kind_i;
            st_d.addr  = addr_i;
        end
        if (ev_i && irq_en_i)                st_d.irq  = 1'b1;
        if (ev_i && mchk_cause_i && mchk_en_i) st_d.mchk = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign cls_o   = st_q.cls;
    assign kind_o  = st_q.kind;
    assign addr_o  = st_q.addr;
    assign irq_o   = st_q.irq;
    assign mchk_o  = st_q.mchk;

    AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && !clr_i |=> valid_o && $stable(addr_o) && $stable(cls_o)); // R8

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !ev_i |=> !valid_o && !irq_o && !mchk_o); // R9

    AST_MCHK_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_o |-> valid_o); // R10

endmodule

// File: rtl/ecc_resp_ctrl.sv
module ecc_resp_ctrl
    import ecc_pkg::*;
#(
    parameter int DW = 64,
    parameter int AW = 32,
    localparam int CB = hbits(DW) + 1,
    localparam int NB = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [1:0]    acc_kind,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic [NB-1:0] acc_be,
    input  logic [DW-1:0] mem_rdata,
    input  logic [CB-1:0] mem_rcheck,
    input  logic          irq_en,
    input  logic          mchk_en,
    input  logic          scrub_wb_en,
    input  logic          stat_clr,
    output logic          host_ack,
    output logic [DW-1:0] host_rdata,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [CB-1:0] mem_wcheck,
    output logic          err_irq,
    output logic          mchk,
    output logic          stat_valid,
    output logic [1:0]    stat_class,
    output logic [1:0]    stat_kind,
    output logic [AW-1:0] stat_addr
);

    typedef struct packed {
        logic          ack;
        logic [DW-1:0] rdata;
        logic          we;
        logic [DW-1:0] wdata;
        logic [CB-1:0] wcheck;
    } resp_t;

    acc_kind_e     kind;
    err_class_e    rd_cls;
    logic [DW-1:0] rd_fix;
    logic [DW-1:0] merged;
    logic [DW-1:0] wr_word;
    logic [CB-1:0] wr_chk;
    logic          err_ev;
    logic          mchk_cause;
    err_class_e    st_cls;
    acc_kind_e     st_kind;
    resp_t         resp_d, resp_q;

    assign kind = acc_kind_e'(acc_kind);

    ecc_decode #(.DW(DW)) u_dec (
        .data_i  (mem_rdata),
        .check_i (mem_rcheck),
        .class_o (rd_cls),
        .data_o  (rd_fix)
    );

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign merged[b*8 +: 8] = acc_be[b] ? acc_wdata[b*8 +: 8] : rd_fix[b*8 +: 8];
    end

    always_comb begin
        case (kind)
            ACC_FWRITE: wr_word = acc_wdata;
            ACC_SCRUB:  wr_word = rd_fix;
            default:    wr_word = merged;
        endcase
    end

    ecc_encode #(.DW(DW)) u_enc (
        .data_i  (wr_word),
        .check_o (wr_chk)
    );

    always_comb begin
        resp_d = '0;
        if (acc_valid) begin
            case (kind)
                ACC_READ: begin
                    resp_d.ack   = 1'b1;
                    resp_d.rdata = (rd_cls == ERR_DOUBLE) ? mem_rdata : rd_fix;
                end
                ACC_PWRITE: begin
                    resp_d.ack = 1'b1;
                    if (rd_cls != ERR_DOUBLE) begin
                        resp_d.we     = 1'b1;
                        resp_d.wdata  = wr_word;
                        resp_d.wcheck = wr_chk;
                    end
                end
                ACC_FWRITE: begin
                    resp_d.we     = 1'b1;
                    resp_d.wdata  = wr_word;
                    resp_d.wcheck = wr_chk;
                end
                default: begin
                    if (rd_cls == ERR_SINGLE && scrub_wb_en) begin
                        resp_d.we     = 1'b1;
                        resp_d.wdata  = wr_word;
                        resp_d.wcheck = wr_chk;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign err_ev     = acc_valid && (kind != ACC_FWRITE) && (rd_cls != ERR_NONE);
    assign mchk_cause = (rd_cls == ERR_DOUBLE) && (kind == ACC_READ || kind == ACC_PWRITE);

    ecc_err_status #(.AW(AW)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (err_ev),
        .cls_i        (rd_cls),
        .kind_i       (kind),
        .addr_i       (acc_addr),
        .mchk_cause_i (mchk_cause),
        .irq_en_i     (irq_en),
        .mchk_en_i    (mchk_en),
        .clr_i        (stat_clr),
        .valid_o      (stat_valid),
        .cls_o        (st_cls),
        .kind_o       (st_kind),
        .addr_o       (stat_addr),
        .irq_o        (err_irq),
        .mchk_o       (mchk)
    );

    assign stat_class = st_cls;
    assign stat_kind  = st_kind;
    assign host_ack   = resp_q.ack;
    assign host_rdata = resp_q.rdata;
    assign mem_we     = resp_q.we;
    assign mem_wdata  = resp_q.wdata;
    assign mem_wcheck = resp_q.wcheck;

    AST_FULL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && kind == ACC_FWRITE |=> mem_we && mem_wdata == $past(acc_wdata)); // R1

    AST_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && kind == ACC_READ |=> host_ack); // R2

    AST_DBL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && kind != ACC_FWRITE && rd_cls == ERR_DOUBLE |=> !mem_we); // R6

    AST_SCRUB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && kind == ACC_SCRUB |=> !host_ack); // R7

endmodule

// File: tb/sim_ecc_resp_ctrl.sv
module sim_ecc_resp_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [31:0] acc_addr = '0;
    logic [63:0] acc_wdata = '0;
    logic [7:0]  acc_be = '0;
    logic [63:0] mem_rdata = '0;
    logic [7:0]  mem_rcheck = '0;
    logic        irq_en = 1'b0;
    logic        mchk_en = 1'b0;
    logic        scrub_wb_en = 1'b0;
    logic        stat_clr = 1'b0;

    logic        host_ack, mem_we, err_irq, mchk, stat_valid;
    logic [63:0] host_rdata, mem_wdata;
    logic [7:0]  mem_wcheck;
    logic [1:0]  stat_class, stat_kind;
    logic [31:0] stat_addr;

    ecc_resp_ctrl u0 (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    // bench-side knowledge of the access
    logic [63:0] tb_clean = '0;
    int          tb_nflip = 0;
    logic        n_irq_en = 1'b0, n_mchk_en = 1'b0, n_wb_en = 1'b0;

    int    vectors = 0;
    int    fails = 0;
    int    cyc = 0;
    string cur_tag = "R12";
    logic  cmp_on = 1'b0;

    // expected outputs and model status
    logic        e_ack, e_we, e_irq, e_mchk, e_sv;
    logic [63:0] e_rdata, e_wdata;
    logic [7:0]  e_wcheck;
    logic [1:0]  e_scls, e_skind;
    logic [31:0] e_saddr;

    function automatic logic [7:0] bchk(input logic [63:0] d);
        logic [6:0] h;
        int pos;
        h = '0;
        pos = 2;
        for (int j = 0; j < 64; j++) begin
            pos++;
            while ((pos & (pos - 1)) == 0) pos++;
            for (int i = 0; i < 7; i++) if (((pos >> i) & 1) == 1) h[i] ^= d[j];
        end
        return {(^d) ^ (^h), h};
    endfunction

    function automatic logic [63:0] bmerge(input logic [63:0] base, input logic [63:0] wd,
                                           input logic [7:0] be);
        logic [63:0] r;
        r = base;
        for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = wd[b*8 +: 8];
        return r;
    endfunction

    // reference model: evaluates the inputs seen at each rising edge
    always @(posedge clk) begin
        int cls;
        logic rw;
        if (!rst_n) begin
            e_ack = 0; e_we = 0; e_irq = 0; e_mchk = 0; e_sv = 0;
            e_rdata = 0; e_wdata = 0; e_wcheck = 0;
            e_scls = 0; e_skind = 0; e_saddr = 0;
        end else begin
            rw = (acc_kind == 2'd0) || (acc_kind == 2'd1);
            cls = (!acc_valid || acc_kind == 2'd2) ? 0 : tb_nflip;
            e_ack = acc_valid && rw;
            e_rdata = (acc_valid && acc_kind == 2'd0) ? ((cls == 2) ? mem_rdata : tb_clean) : 64'd0;
            e_we = 1'b0;
            e_wdata = 64'd0;
            if (acc_valid) begin
                if (acc_kind == 2'd2) begin e_we = 1; e_wdata = acc_wdata; end
                else if (acc_kind == 2'd1 && cls < 2) begin
                    e_we = 1; e_wdata = bmerge(tb_clean, acc_wdata, acc_be);
                end else if (acc_kind == 2'd3 && cls == 1 && scrub_wb_en) begin
                    e_we = 1; e_wdata = tb_clean;
                end
            end
            e_wcheck = e_we ? bchk(e_wdata) : 8'd0;
            if (stat_clr) begin
                e_sv = 0; e_scls = 0; e_skind = 0; e_saddr = 0;
            end
            if (cls != 0 && (!e_sv || stat_clr)) begin
                e_sv = 1; e_scls = 2'(cls); e_skind = acc_kind; e_saddr = acc_addr;
            end
            e_irq  = (e_irq && !stat_clr) || (cls != 0 && irq_en);
            e_mchk = (e_mchk && !stat_clr) || (cls == 2 && rw && mchk_en);
        end
    end

    task automatic cmp(input string tag, input string fld, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (step %s) act=%h exp=%h at %0t", tag, fld, cur_tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            cmp("R2",  "host_ack",   64'(host_ack),   64'(e_ack));
            cmp("R3",  "host_rdata", host_rdata,      e_rdata);
            cmp("R5",  "mem_we",     64'(mem_we),     64'(e_we));
            cmp("R5",  "mem_wdata",  mem_wdata,       e_wdata);
            cmp("R1",  "mem_wcheck", 64'(mem_wcheck), 64'(e_wcheck));
            cmp("R10", "err_irq",    64'(err_irq),    64'(e_irq));
            cmp("R10", "mchk",       64'(mchk),       64'(e_mchk));
            cmp("R8",  "stat_valid", 64'(stat_valid), 64'(e_sv));
            cmp("R8",  "stat_class", 64'(stat_class), 64'(e_scls));
            cmp("R8",  "stat_kind",  64'(stat_kind),  64'(e_skind));
            cmp("R8",  "stat_addr",  64'(stat_addr),  64'(e_saddr));
        end
    end

    task automatic finish_up;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    // one access for one cycle; f0/f1 are stored-bit indices to flip (-1: none),
    // bits 0..63 data, 64..71 check
    task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [63:0] clean,
                       input logic [63:0] wd, input logic [7:0] be,
                       input int f0, input int f1, input logic clr);
        logic [71:0] cw;
        int n;
        @(negedge clk);
        cw = {bchk(clean), clean};
        n = 0;
        if (f0 >= 0) begin cw[f0] = ~cw[f0]; n++; end
        if (f1 >= 0) begin cw[f1] = ~cw[f1]; n++; end
        acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_wdata = wd; acc_be = be;
        mem_rdata = cw[63:0]; mem_rcheck = cw[71:64];
        tb_clean = clean; tb_nflip = n;
        irq_en = n_irq_en; mchk_en = n_mchk_en; scrub_wb_en = n_wb_en; stat_clr = clr;
    endtask

    task automatic idle(input logic clr);
        @(negedge clk);
        acc_valid = 1'b0; tb_nflip = 0; stat_clr = clr;
        irq_en = n_irq_en; mchk_en = n_mchk_en; scrub_wb_en = n_wb_en;
    endtask

    initial begin
        cmp_on = 1'b1;
        cur_tag = "R12";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(0);

        // R1, R11: full write encodes; corrupted memory word ignored
        cur_tag = "R11";
        n_irq_en = 1; n_mchk_en = 1;
        acc(2'd2, 32'h100, 64'h0, 64'h0123_4567_89ab_cdef, 8'h00, 5, 70, 0);
        acc(2'd2, 32'h108, 64'h0, 64'hffff_ffff_ffff_ffff, 8'h00, 3, -1, 0);
        idle(0);

        // R2, R3: clean read, single flip in data, in a check bit, in parity bit
        cur_tag = "R3";
        n_irq_en = 0; n_mchk_en = 0;
        acc(2'd0, 32'h200, 64'hdead_beef_cafe_f00d, 64'h0, 8'h00, -1, -1, 0);
        acc(2'd0, 32'h208, 64'h1111_2222_3333_4444, 64'h0, 8'h00, 17, -1, 0);
        acc(2'd0, 32'h210, 64'h5555_aaaa_5555_aaaa, 64'h0, 8'h00, 66, -1, 0);
        acc(2'd0, 32'h218, 64'h8000_0000_0000_0001, 64'h0, 8'h00, 71, -1, 0);
        idle(1);

        // R4: uncorrectable read returns raw data, mchk when enabled
        cur_tag = "R4";
        n_irq_en = 1; n_mchk_en = 1;
        acc(2'd0, 32'h300, 64'h0f0f_0f0f_0f0f_0f0f, 64'h0, 8'h00, 0, 63, 0);
        idle(0);
        // R8: a later error must not overwrite the status
        cur_tag = "R8";
        acc(2'd0, 32'h308, 64'h1234, 64'h0, 8'h00, 9, -1, 0);
        idle(1);

        // R5: partial writes, clean and single
        cur_tag = "R5";
        n_irq_en = 1; n_mchk_en = 0;
        acc(2'd1, 32'h400, 64'haaaa_bbbb_cccc_dddd, 64'h1122_3344_5566_7788, 8'h5a, -1, -1, 0);
        acc(2'd1, 32'h408, 64'haaaa_bbbb_cccc_dddd, 64'h1122_3344_5566_7788, 8'h81, 40, -1, 0);
        acc(2'd1, 32'h410, 64'h0123_0000_0000_ffff, 64'h9999_9999_9999_9999, 8'h00, 2, -1, 0);
        acc(2'd1, 32'h418, 64'h0, 64'h7777_6666_5555_4444, 8'hff, 64, -1, 0);
        idle(1);

        // R6: partial write double, no write; R9 clear with simultaneous error
        cur_tag = "R6";
        n_mchk_en = 1;
        acc(2'd1, 32'h500, 64'h4242, 64'hffff, 8'h03, 1, 2, 0);
        cur_tag = "R9";
        acc(2'd0, 32'h508, 64'h77, 64'h0, 8'h00, 30, 31, 1);
        idle(1);
        idle(0);

        // R7: scrubs
        cur_tag = "R7";
        n_wb_en = 0;
        acc(2'd3, 32'h600, 64'hfeed_face, 64'h0, 8'h00, 12, -1, 0);
        n_wb_en = 1;
        acc(2'd3, 32'h608, 64'hfeed_face, 64'h0, 8'h00, 12, -1, 1);
        acc(2'd3, 32'h610, 64'hfeed_face, 64'h0, 8'h00, -1, -1, 1);
        acc(2'd3, 32'h618, 64'hfeed_face, 64'h0, 8'h00, 12, 13, 1);
        idle(1);
        idle(0);

        // mixed traffic
        cur_tag = "R10";
        for (int it = 0; it < 600; it++) begin
            int r;
            int p0;
            int p1;
            n_irq_en = 1'($urandom);
            n_mchk_en = 1'($urandom);
            n_wb_en = 1'($urandom);
            r = int'($urandom % 4);
            p0 = -1; p1 = -1;
            if (r == 1) p0 = int'($urandom % 72);
            if (r == 2) begin
                p0 = int'($urandom % 72);
                p1 = (p0 + 1 + int'($urandom % 71)) % 72;
            end
            if ($urandom % 8 == 0) idle(($urandom % 10) == 0);
            else acc(2'($urandom), $urandom, {$urandom, $urandom}, {$urandom, $urandom},
                     8'($urandom), p0, p1, ($urandom % 10) == 0);
        end
        idle(0);
        idle(0);
        @(negedge clk);
        cmp_on = 1'b0;
        finish_up();
    end

endmodule